// File: doc/BRIEF.md
# Phase-offset PWM channel bank

This block produces a set of pulse-width-modulated outputs from one shared 12-bit phase counter. The counter steps once per clock through 0 to 4095 and wraps. Each channel has its own rise count and fall count, so pulses of different channels can sit at different offsets within the period. Each channel also has a force-high bit and a force-low bit that override the counts.

Software writes new settings one byte at a time over a plain write strobe with address and data. Those writes land in staging registers. A channel copies its staged settings into its live settings only at the last count of a low phase. A pulse is therefore never cut short or stretched while a byte-wise update is still in progress. A group of broadcast addresses writes the same pattern into the staging registers of every channel at once.

A shared output stage applies a polarity bit. It also applies an active-low enable pin: while the pin is high, a park mode decides whether each output is driven low, driven high, or released to high impedance.

Top module: `pwm_phase_bank`

## Requirements
- R1: `phase` resets to 0, rises by one on every clock and wraps from 4095 to 0.
- R2: With both override bits clear and rise count ≠ fall count, the raw level is high for counts in [rise, fall) when rise < fall, and for counts ≥ rise or < fall when fall < rise. `pwm_out` shows the level for the `phase` value of the previous cycle. Per channel c the byte map is as follows:
  - address 4c+0 holds rise[7:0];
  - address 4c+1 holds rise[11:8] in bits 3:0 and the force-high bit in bit 4;
  - address 4c+2 holds fall[7:0];
  - address 4c+3 holds fall[11:8] in bits 3:0 and the force-low bit in bit 4.
- R3: With the force-high bit set and the force-low bit clear, the raw level is high all period.
- R4: The force-low bit makes the raw level low, even when the force-high bit is also set.
- R5: When the rise count equals the fall count and neither override bit is set, the raw level is low.
- R6: After a write, the channel keeps its previous live settings until the commit point, and then takes the staged values. For a pattern with edges, the commit point is the count just before the next rise. For a pattern with no edges (either override bit set, or equal counts), the commit point is count 4095.
- R7: A write to address 60+k (k = 0..3) does what a write to 4c+k does, for every channel c.
- R8: While `oe_n` is low, each output is driven and equals the raw level XOR the polarity bit. The polarity bit is bit 0 of the config register at address 59.
- R9: While `oe_n` is high, the park mode (config bits 3:2) sets the outputs as follows:
  - 00 drives 0;
  - 01 drives 1 if the push-pull bit (config bit 1) is set, and gives high impedance otherwise;
  - 10 and 11 give high impedance.
  High impedance shows as `pwm_drive`=0 and `pwm_out`=0.
- R10: `rd_data` returns the staged byte at `rd_addr` one cycle later. High bytes read bits 7:5 as 0. The config register reads {4'b0, bits 3:0}. Broadcast and unused addresses read 0.
- R11: While `rst` is high, the outputs show `pwm_out`=0, `pwm_drive`=0, `phase`=0 and `rd_data`=0. Staged and live counts reset to 0, both override bits reset to 1, and the config register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 8 | Registered read byte |
| oe_n | input | 1 | Active-low output enable |
| phase | output | 12 | Shared phase counter |
| pwm_out | output | NCH | Output level per channel |
| pwm_drive | output | NCH | 1 = output driven, 0 = high impedance |

## Verification
The hardest case to reach is a write that lands in the middle of a high pulse. The output must then finish the old pulse and switch to the new values only at the end of the next low phase. The stimulus waits for `phase` to sit inside channel 0's pulse before it writes counts that would already be low at that point. It then samples the output a little later in the same pulse. Wrap-around windows, a rise at count 0 with a fall at 4095, and the reverse are reached through broadcast writes that feed every channel the same boundary pattern.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned HI_W  = CNT_W - 8;

  typedef struct packed {
    logic             full_on;
    logic             full_off;
    logic [CNT_W-1:0] on_cnt;
    logic [CNT_W-1:0] off_cnt;
  } slot_t;

  localparam slot_t SLOT_RST = '{full_on: 1'b1, full_off: 1'b1, on_cnt: '0, off_cnt: '0};

  typedef struct packed {
    logic [1:0] park_mode;
    logic       push_pull;
    logic       invert;
  } outcfg_t;
endpackage

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter import pwm_bank_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase == CNT_W'($past(phase) + 1'b1)); // R1
endmodule

// File: rtl/pwm_stage_regs.sv
module pwm_stage_regs import pwm_bank_pkg::*; #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [7:0]      rd_data,
  output slot_t [NCH-1:0] stage,
  output logic [NCH-1:0]  stage_wr,
  output outcfg_t         cfg
);
  localparam int unsigned GW       = AW - 2;
  localparam int unsigned BC_GRP   = (2 ** GW) - 1;
  localparam int unsigned CFG_ADDR = (2 ** AW) - 5;

  slot_t stg_q [NCH];
  logic [GW-1:0] wr_grp, rd_grp;
  logic [1:0]    wr_sel, rd_sel;
  logic          cfg_hit;
  logic [7:0]    rd_mux;

  assign wr_grp  = wr_addr[AW-1:2];
  assign wr_sel  = wr_addr[1:0];
  assign rd_grp  = rd_addr[AW-1:2];
  assign rd_sel  = rd_addr[1:0];
  assign cfg_hit = wr_en && (wr_addr == AW'(CFG_ADDR));

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    assign stage_wr[c] = wr_en && ((wr_grp == GW'(c)) || (wr_grp == GW'(BC_GRP)));
    assign stage[c]    = stg_q[c];
  end

  function automatic logic [7:0] slot_byte(slot_t s, logic [1:0] sel);
    case (sel)
      2'd0:    return s.on_cnt[7:0];
      2'd1:    return {3'b000, s.full_on, s.on_cnt[CNT_W-1:8]};
      2'd2:    return s.off_cnt[7:0];
      default: return {3'b000, s.full_off, s.off_cnt[CNT_W-1:8]};
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) stg_q[c] <= SLOT_RST;
      cfg <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (stage_wr[c]) begin
          case (wr_sel)
            2'd0: stg_q[c].on_cnt[7:0] <= wr_data;
            2'd1: begin
              stg_q[c].on_cnt[CNT_W-1:8] <= wr_data[HI_W-1:0];
              stg_q[c].full_on           <= wr_data[4];
            end
            2'd2: stg_q[c].off_cnt[7:0] <= wr_data;
            default: begin
              stg_q[c].off_cnt[CNT_W-1:8] <= wr_data[HI_W-1:0];
              stg_q[c].full_off           <= wr_data[4];
            end
          endcase
        end
      end
      if (cfg_hit) cfg <= outcfg_t'(wr_data[3:0]);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == AW'(CFG_ADDR)) begin
      rd_mux = {4'b0000, cfg};
    end else begin
      for (int c = 0; c < NCH; c++)
        if (rd_grp == GW'(c)) rd_mux = slot_byte(stg_q[c], rd_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_addr[0])) |-> rd_data[7:5] == 3'b000); // R10
endmodule

// File: rtl/pwm_slot_chan.sv
module pwm_slot_chan import pwm_bank_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] phase,
  input  slot_t            stg,
  input  logic             stg_wr,
  input  logic             oe_n,
  input  outcfg_t          cfg,
  output logic             pin_lvl,
  output logic             pin_drv
);
  localparam logic [CNT_W-1:0] TOP = '1;

  slot_t            act;
  logic             pend;
  logic [CNT_W-1:0] phase_nx;
  logic             lvl_now, lvl_nx, steady, commit;

  function automatic logic slot_level(slot_t s, logic [CNT_W-1:0] p);
    if (s.full_off) return 1'b0;
    if (s.full_on) return 1'b1;
    if (s.on_cnt == s.off_cnt) return 1'b0;
    if (s.on_cnt < s.off_cnt) return (p >= s.on_cnt) && (p < s.off_cnt);
    return (p >= s.on_cnt) || (p < s.off_cnt);
  endfunction

  always_comb begin
    phase_nx = phase + 1'b1;
    lvl_now  = slot_level(act, phase);
    lvl_nx   = slot_level(act, phase_nx);
    steady   = act.full_off || act.full_on || (act.on_cnt == act.off_cnt);
    commit   = pend && (steady ? (phase == TOP) : (!lvl_now && lvl_nx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= SLOT_RST;
      pend <= 1'b0;
    end else begin
      if (commit) act <= stg;
      if (stg_wr)      pend <= 1'b1;
      else if (commit) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_lvl <= 1'b0;
      pin_drv <= 1'b0;
    end else if (!oe_n) begin
      pin_lvl <= lvl_now ^ cfg.invert;
      pin_drv <= 1'b1;
    end else begin
      case (cfg.park_mode)
        2'b00: begin pin_lvl <= 1'b0;          pin_drv <= 1'b1; end
        2'b01: begin pin_lvl <= cfg.push_pull; pin_drv <= cfg.push_pull; end
        default: begin pin_lvl <= 1'b0;        pin_drv <= 1'b0; end
      endcase
    end
  end

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pend)) |-> $stable(act)); // R6
  AST_FON_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(oe_n) && $past(act.full_on && !act.full_off))
      |-> pin_lvl == !$past(cfg.invert)); // R3
  AST_FOFF_WINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(oe_n) && $past(act.full_off))
      |-> pin_lvl == $past(cfg.invert)); // R4
  AST_EQ_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(oe_n) && $past(!act.full_on && act.on_cnt == act.off_cnt))
      |-> pin_lvl == $past(cfg.invert)); // R5
  AST_PARK_HIZ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(oe_n) && $past(cfg.park_mode[1])) |-> !pin_drv); // R9
endmodule

// File: rtl/pwm_phase_bank.sv
module pwm_phase_bank import pwm_bank_pkg::*; #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  input  logic             oe_n,
  output logic [CNT_W-1:0] phase,
  output logic [NCH-1:0]   pwm_out,
  output logic [NCH-1:0]   pwm_drive
);
  slot_t [NCH-1:0] stage;
  logic  [NCH-1:0] stage_wr;
  outcfg_t         cfg;

  pwm_phase_counter i_counter (
    .clk   (clk),
    .rst   (rst),
    .phase (phase)
  );

  pwm_stage_regs #(.NCH(NCH), .AW(AW)) i_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .stage    (stage),
    .stage_wr (stage_wr),
    .cfg      (cfg)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_slot_chan i_chan (
      .clk     (clk),
      .rst     (rst),
      .phase   (phase),
      .stg     (stage[c]),
      .stg_wr  (stage_wr[c]),
      .oe_n    (oe_n),
      .cfg     (cfg),
      .pin_lvl (pwm_out[c]),
      .pin_drv (pwm_drive[c])
    );
  end

  AST_HIZ_LOW: assert property (@(posedge clk) disable iff (rst)
    (pwm_out & ~pwm_drive) == '0); // R9
endmodule

// File: tb/test_pwm_phase_bank.sv
module test_pwm_phase_bank;
  import pwm_bank_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int AW         = 6;
  localparam int CFG_ADDR   = 59;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic oe_n = 1'b0;
  logic [7:0] rd_data;
  logic [CNT_W-1:0] phase;
  logic [NCH-1:0] pwm_out, pwm_drive;

  int n_chk = 0;
  int n_fail = 0;
  int n_cyc = 0;

  pwm_phase_bank #(.NCH(NCH), .AW(AW)) i_pwm_phase_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .oe_n(oe_n), .phase(phase),
    .pwm_out(pwm_out), .pwm_drive(pwm_drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [CNT_W-1:0] ph;
    logic [NCH-1:0]   lv;
    logic [NCH-1:0]   dv;
    logic [7:0]       rd;
  } exp_t;

  exp_t    sb_q[$];
  slot_t   m_stg [NCH];
  slot_t   m_act [NCH];
  logic    m_pend [NCH];
  outcfg_t m_cfg;
  logic [CNT_W-1:0] m_cnt;
  string   m_tag [NCH];
  string   m_gtag;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, n_cyc);
    end
  endtask

  function automatic logic lvl_of(slot_t s, logic [CNT_W-1:0] p);
    if (s.full_off) return 1'b0;
    if (s.full_on) return 1'b1;
    if (s.on_cnt == s.off_cnt) return 1'b0;
    if (s.on_cnt < s.off_cnt) return (p >= s.on_cnt) && (p < s.off_cnt);
    return (p >= s.on_cnt) || (p < s.off_cnt);
  endfunction

  function automatic logic [7:0] rd_of(logic [AW-1:0] a);
    int g = int'(a) / 4;
    if (int'(a) == CFG_ADDR) return {4'b0000, m_cfg};
    if (g >= NCH) return 8'h00;
    case (a[1:0])
      2'd0: return m_stg[g].on_cnt[7:0];
      2'd1: return {3'b000, m_stg[g].full_on, m_stg[g].on_cnt[CNT_W-1:8]};
      2'd2: return m_stg[g].off_cnt[7:0];
      default: return {3'b000, m_stg[g].full_off, m_stg[g].off_cnt[CNT_W-1:8]};
    endcase
  endfunction

  // Driver side of the scoreboard: predicts each edge and queues the result.
  task automatic predict();
    exp_t e;
    logic commit [NCH];
    if (rst) begin
      e = '0;
      for (int c = 0; c < NCH; c++) begin
        m_stg[c] = SLOT_RST; m_act[c] = SLOT_RST; m_pend[c] = 1'b0; m_tag[c] = "R11";
      end
      m_cfg = '0; m_cnt = '0; m_gtag = "R11";
    end else begin
      m_gtag = "R1";
      e.ph = m_cnt + 1'b1;
      e.rd = rd_of(rd_addr);
      for (int c = 0; c < NCH; c++) begin
        logic l, ln, st;
        l  = lvl_of(m_act[c], m_cnt);
        ln = lvl_of(m_act[c], m_cnt + 1'b1);
        st = m_act[c].full_off || m_act[c].full_on || (m_act[c].on_cnt == m_act[c].off_cnt);
        commit[c] = m_pend[c] && (st ? (m_cnt == '1) : (!l && ln));
        if (!oe_n) begin
          e.lv[c] = l ^ m_cfg.invert; e.dv[c] = 1'b1;
        end else if (m_cfg.park_mode == 2'b00) begin
          e.lv[c] = 1'b0; e.dv[c] = 1'b1;
        end else if (m_cfg.park_mode == 2'b01) begin
          e.lv[c] = m_cfg.push_pull; e.dv[c] = m_cfg.push_pull;
        end else begin
          e.lv[c] = 1'b0; e.dv[c] = 1'b0;
        end
        if (oe_n) m_tag[c] = "R9";
        else if (m_pend[c]) m_tag[c] = "R6";
        else if (m_act[c].full_off) m_tag[c] = "R4";
        else if (m_act[c].full_on) m_tag[c] = "R3";
        else if (m_act[c].on_cnt == m_act[c].off_cnt) m_tag[c] = "R5";
        else if (m_cfg.invert) m_tag[c] = "R8";
        else m_tag[c] = "R2";
      end
      m_cnt = m_cnt + 1'b1;
      for (int c = 0; c < NCH; c++) begin
        bit hit;
        hit = wr_en && ((int'(wr_addr) / 4 == c) || (int'(wr_addr) / 4 == 15));
        if (commit[c]) m_act[c] = m_stg[c];
        if (hit) m_pend[c] = 1'b1;
        else if (commit[c]) m_pend[c] = 1'b0;
        if (hit) begin
          case (wr_addr[1:0])
            2'd0: m_stg[c].on_cnt[7:0] = wr_data;
            2'd1: begin m_stg[c].on_cnt[CNT_W-1:8] = wr_data[3:0]; m_stg[c].full_on = wr_data[4]; end
            2'd2: m_stg[c].off_cnt[7:0] = wr_data;
            default: begin m_stg[c].off_cnt[CNT_W-1:8] = wr_data[3:0]; m_stg[c].full_off = wr_data[4]; end
          endcase
        end
      end
      if (wr_en && int'(wr_addr) == CFG_ADDR) m_cfg = outcfg_t'(wr_data[3:0]);
    end
    sb_q.push_back(e);
  endtask

  // Monitor side: pops each prediction and compares it with the ports.
  always @(negedge clk) begin
    exp_t e;
    n_cyc++;
    predict();
    e = sb_q.pop_front();
    chk(phase == e.ph, m_gtag, phase, e.ph);                          // R1
    chk(rd_data == e.rd, (m_gtag == "R11") ? "R11" : "R10", rd_data, e.rd); // R10
    for (int c = 0; c < NCH; c++) begin
      chk(pwm_out[c] == e.lv[c], m_tag[c], pwm_out[c], e.lv[c]);
      chk(pwm_drive[c] == e.dv[c], m_tag[c], pwm_drive[c], e.dv[c]);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wr_slot(input int base, input int on, input int off, input bit fon, input bit foff);
    wr(base + 0, on & 8'hFF);
    wr(base + 1, ((on >> 8) & 4'hF) | (fon ? 8'h10 : 8'h00));
    wr(base + 2, off & 8'hFF);
    wr(base + 3, ((off >> 8) & 4'hF) | (foff ? 8'h10 : 8'h00));
  endtask

  task automatic wait_phase(input int v);
    do @(negedge clk); while (int'(phase) != v);
    #1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual cycles %0d expected below %0d", n_cyc, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    chk(pwm_out == '0 && pwm_drive == '0, "R11", {pwm_out, pwm_drive}, 0);
    chk(phase == '0, "R11", phase, 0);
    rst = 1'b0;
    // R2 normal and wrapped windows, R5 equal counts, R3 force-high
    wr_slot(0, 100, 300, 0, 0);
    wr_slot(4, 3000, 500, 0, 0);
    wr_slot(8, 700, 700, 0, 0);
    wr_slot(12, 5, 9, 1, 0);
    rd_addr = 6'd1; step(2);
    chk(rd_data == 8'h00, "R10", rd_data, 8'h00);
    wait_phase(4095); wait_phase(4095);
    // R6: write mid-pulse, old pulse must finish
    wait_phase(200);
    wr_slot(0, 1000, 1200, 0, 0);
    wait_phase(251);
    chk(pwm_out[0] == 1'b1, "R6", pwm_out[0], 1);
    wait_phase(4000); wait_phase(1300);
    // R4: both overrides set on channel 0
    wr(1, 8'h10); wr(3, 8'h10);
    wait_phase(4095); wait_phase(2000);
    // R8 polarity
    wr(CFG_ADDR, 8'h01);
    wait_phase(4095); wait_phase(1000);
    // R9 park modes
    oe_n = 1'b1;
    wr(CFG_ADDR, 8'h00); step(20);
    wr(CFG_ADDR, 8'h04); step(20);
    wr(CFG_ADDR, 8'h06); step(20);
    wr(CFG_ADDR, 8'h08); step(20);
    wr(CFG_ADDR, 8'h0E); step(20);
    rd_addr = 6'(CFG_ADDR); step(2);
    chk(rd_data == 8'h0E, "R10", rd_data, 8'h0E);
    wr(CFG_ADDR, 8'h00);
    oe_n = 1'b0;
    // R7 broadcast, rise at 0 and fall at 4095
    wr_slot(60, 0, 4095, 0, 0);
    for (int c = 0; c < NCH; c++) begin
      rd_addr = 6'(4 * c + 3); step(2);
      chk(rd_data == 8'h0F, "R7", rd_data, 8'h0F);
      rd_addr = 6'(4 * c + 1); step(2);
      chk(rd_data == 8'h00, "R7", rd_data, 8'h00);
    end
    wait_phase(4095); wait_phase(4095); wait_phase(10);
    // rise at 4095 and fall at 0
    wr_slot(60, 4095, 0, 0, 0);
    wait_phase(4095); wait_phase(4095); wait_phase(20);
    // R10 reserved bits after writing all ones to a high byte
    wr(5, 8'hFF);
    rd_addr = 6'd5; step(2);
    chk(rd_data == 8'h1F, "R10", rd_data, 8'h1F);
    for (int a = 0; a < 64; a++) begin
      rd_addr = 6'(a); step(2);
    end
    step(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule